// File: doc/BRIEF.md
# Low-Power Compare Timer

This block is a slow-clock counter with a compare register, a compare flag with an interrupt, and a hardware trigger. The counter advances on rising edges of one of four slow clock sources. Each source is synchronised into the bus clock domain and is picked by a select field. In pulse mode the counter advances on edges of a separate pulse input instead. Edges pass through a prescaler that divides by a power of two or is bypassed. The counter either wraps only on overflow or returns to zero after it reaches the compare value.

Software reaches the block through a small word-addressed register bus with four registers: control, prescaler, compare and counter snapshot. The running count is never read directly. A write of any value to the snapshot register latches the count, and reads of that register return the latched value. Clearing the enable bit returns the counter, the prescaler, the enable synchroniser and the flag to their idle state. The first two selected edges after enable are consumed by the enable synchroniser, so the first increment comes late.

Top module: `lpc_timer`

## Requirements
- R1: After reset, all four registers read 0, and `irq_o` and `trig_o` are 0.
- R2: A write to address 3 latches the current count. Reads of address 3 return that latched value, and it does not change until the next write to address 3.
- R3: After the enable bit (control bit 0) is set, the first two selected edges do not count. The third edge is the first one fed to the prescaler.
- R4: With control bit 2 at 0 (match-reset), the count runs 0, 1, …, compare and then returns to 0 on the next count event. After E events the count is E mod (compare+1).
- R5: With control bit 2 at 1 (free-run), the count wraps only on overflow. After E events it is E mod 2^CNT_W, whatever the compare value.
- R6: The flag (control bit 7) is set when the count reaches the compare value. Writing 1 to control bit 7 clears it. `irq_o` is high exactly when the flag and the interrupt enable (control bit 3) are both set.
- R7: In match-reset mode with compare value 0, `trig_o` stays high for as long as the timer is enabled and drops once it is disabled. `trig_o` is never high while the timer is disabled.
- R8: Clearing the enable bit clears the count, the flag, the prescaler and the enable synchroniser.
- R9: While the timer is enabled and the flag is clear, writes to the compare register (address 2) are ignored. They take effect while the flag is set or while the timer is disabled.
- R10: With prescaler bit 4 at 1, every selected edge is a count event. With bit 4 at 0, one event occurs per 2^(d+1) edges, where d is prescaler bits 3:0.
- R11: Prescaler bits 6:5 select which of `src_clk_i[3:0]` is counted. Edges on the other sources have no effect.
- R12: With control bit 1 at 1 (pulse mode), edges of `pulse_i` are counted and the clock sources are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 control, 1 prescaler, 2 compare, 3 snapshot |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| src_clk_i | input | 4 | Slow clock sources (asynchronous levels) |
| pulse_i | input | 1 | External pulse input for pulse mode |
| irq_o | output | 1 | Interrupt: flag gated by interrupt enable |
| trig_o | output | 1 | Hardware trigger: high while enabled and count equals compare |

## Verification
The counting path is swept in match-reset mode for several compare values, one event at a time. This separates a wrap at compare from a wrap at compare+1. A long free-run stretch past 2^8 on a narrow counter separates an overflow wrap from a compare wrap. Edge trains of different lengths are sent through prescaler settings 0 to 2 and through bypass, which exposes an off-by-one in the divider limit. Each clock-source select value is driven with edges on the other sources first, and pulse mode is driven with clock edges first. This confirms that the unselected inputs are ignored. Targeted sequences cover a snapshot read with no prior write, the compare-0 held trigger, compare writes made with and without the flag, and disabling mid-count.

// File: rtl/lpct_pkg.sv
package lpct_pkg;
    localparam int BUS_W    = 32;
    localparam int PRE_W    = 4;
    localparam int NSRC     = 4;
    localparam int SEL_W    = $clog2(NSRC);
    localparam int PCNT_W   = 1 << PRE_W;
    localparam int FLAG_BIT = 7;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_PRE  = 2'd1,
        A_CMP  = 2'd2,
        A_SNAP = 2'd3
    } addr_e;

    typedef struct packed {
        logic irq_en;
        logic free_run;
        logic pulse_mode;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic [SEL_W-1:0] src;
        logic             bypass;
        logic [PRE_W-1:0] div;
    } pre_t;

    // Terminal prescaler count for a division of 2^(d+1)
    function automatic logic [PCNT_W-1:0] div_limit(input logic [PRE_W-1:0] d);
        logic [PCNT_W:0] one;
        int sh;
        one = 1;
        sh  = int'(d) + 1;
        return PCNT_W'((one << sh) - 1);
    endfunction
endpackage

// File: rtl/lpct_regs.sv
module lpct_regs
    import lpct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             flag_set_i,
    output ctrl_t            ctrl_o,
    output pre_t             pre_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic [CNT_W-1:0] snap_o,
    output logic             flag_o
);
    localparam int CTRL_W = $bits(ctrl_t);
    localparam int PRE_B  = $bits(pre_t);

    ctrl_t            ctrl_q;
    pre_t             pre_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] snap_q;
    logic             flag_q;
    logic             wr_en;
    addr_e            addr;

    assign wr_en = bus_sel && bus_wr;
    assign addr  = addr_e'(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            pre_q  <= '0;
            cmp_q  <= '0;
            snap_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_en && addr == A_CTRL) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr_en && addr == A_PRE)  pre_q  <= pre_t'(bus_wdata[PRE_B-1:0]);
            if (wr_en && addr == A_CMP && (!ctrl_q.enable || flag_q))
                cmp_q <= bus_wdata[CNT_W-1:0];
            if (wr_en && addr == A_SNAP) snap_q <= cnt_i;
            if (!ctrl_q.enable)
                flag_q <= 1'b0;
            else if (flag_set_i)
                flag_q <= 1'b1;
            else if (wr_en && addr == A_CTRL && bus_wdata[FLAG_BIT])
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (addr)
            A_CTRL: begin
                bus_rdata[CTRL_W-1:0] = ctrl_q;
                bus_rdata[FLAG_BIT]   = flag_q;
            end
            A_PRE:  bus_rdata[PRE_B-1:0] = pre_q;
            A_CMP:  bus_rdata = BUS_W'(cmp_q);
            default: bus_rdata = BUS_W'(snap_q);
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign pre_o  = pre_q;
    assign cmp_o  = cmp_q;
    assign snap_o = snap_q;
    assign flag_o = flag_q;
endmodule

// File: rtl/lpct_tickgen.sv
module lpct_tickgen
    import lpct_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_i,
    input  logic            pulse_i,
    input  ctrl_t           ctrl,
    input  pre_t            pre,
    output logic            evt_o
);
    localparam int NIN = NSRC + 1;

    logic [NIN-1:0] raw_in;
    logic [NIN-1:0] s2;
    logic [NIN-1:0] prev;
    logic [NIN-1:0] edges;

    assign raw_in = {pulse_i, src_i};

    // Two-flop synchroniser and edge detector per input
    for (genvar i = 0; i < NIN; i++) begin : g_sync
        logic s1_q, s2_q, p_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
                p_q  <= 1'b0;
            end else begin
                s1_q <= raw_in[i];
                s2_q <= s1_q;
                p_q  <= s2_q;
            end
        end
        assign s2[i]   = s2_q;
        assign prev[i] = p_q;
    end

    assign edges = s2 & ~prev;

    logic              tick;
    logic [1:0]        en_s;
    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] lim;
    logic              live_tick;

    assign tick      = ctrl.pulse_mode ? edges[NSRC] : edges[pre.src];
    assign lim       = div_limit(pre.div);
    assign live_tick = tick && en_s[1];
    assign evt_o     = live_tick && (pre.bypass || pcnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !ctrl.enable) begin
            en_s <= '0;
            pcnt <= '0;
        end else begin
            if (tick) en_s <= {en_s[0], 1'b1};
            if (live_tick) begin
                if (pre.bypass || pcnt == lim) pcnt <= '0;
                else                           pcnt <= pcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lpct_core.sv
module lpct_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             free_run,
    input  logic             evt,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_set_o,
    output logic             trig_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             match;
    logic             match_prev;

    assign match = (cnt_q == cmp);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt_q      <= '0;
            match_prev <= 1'b0;
        end else begin
            match_prev <= match;
            if (evt) begin
                if (!free_run && match) cnt_q <= '0;
                else                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign flag_set_o = enable && match && !match_prev;
    assign trig_o     = enable && match;
    assign cnt_o      = cnt_q;
endmodule

// File: rtl/lpc_timer.sv
module lpc_timer
    import lpct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [3:0]  src_clk_i,
    input  logic        pulse_i,
    output logic        irq_o,
    output logic        trig_o
);
    ctrl_t            ctrl;
    pre_t             pre;
    logic [CNT_W-1:0] cmp_val;
    logic [CNT_W-1:0] snap_val;
    logic [CNT_W-1:0] cnt_val;
    logic             flag;
    logic             flag_set;
    logic             evt;

    lpct_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_i(cnt_val), .flag_set_i(flag_set),
        .ctrl_o(ctrl), .pre_o(pre), .cmp_o(cmp_val),
        .snap_o(snap_val), .flag_o(flag)
    );

    lpct_tickgen tick_i (
        .clk(clk), .rst(rst),
        .src_i(src_clk_i), .pulse_i(pulse_i),
        .ctrl(ctrl), .pre(pre), .evt_o(evt)
    );

    lpct_core #(.CNT_W(CNT_W)) core_i (
        .clk(clk), .rst(rst),
        .enable(ctrl.enable), .free_run(ctrl.free_run),
        .evt(evt), .cmp(cmp_val),
        .cnt_o(cnt_val), .flag_set_o(flag_set), .trig_o(trig_o)
    );

    assign irq_o = flag && ctrl.irq_en;
endmodule

// File: rtl/lpct_chk.sv
module lpct_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic             enable,
    input logic             flag,
    input logic             irq,
    input logic             trig,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp,
    input logic [CNT_W-1:0] snap
);
    logic snap_wr, cmp_wr;
    assign snap_wr = bus_sel && bus_wr && bus_addr == 2'd3;
    assign cmp_wr  = bus_sel && bus_wr && bus_addr == 2'd2;

    p_snap_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !snap_wr |=> $stable(snap));

    p_first_delay_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(enable) |=> cnt == '0);

    p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && cnt != $past(cnt)) |->
        (cnt == $past(cnt) + CNT_W'(1) || cnt == '0));

    p_irq_flag_r6: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);

    p_trig_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !trig);

    p_disable_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(enable) |=> (cnt == '0 && !flag));

    p_cmp_locked_r9: assert property (@(posedge clk) disable iff (rst)
        (cmp_wr && enable && !flag) |=> $stable(cmp));
endmodule

bind lpc_timer lpct_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .enable(ctrl.enable), .flag(flag), .irq(irq_o), .trig(trig_o),
    .cnt(cnt_val), .cmp(cmp_val), .snap(snap_val)
);

// File: tb/lpc_timer_tb_top.sv
module lpc_timer_tb_top;
    localparam int W = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_wr;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [3:0]  src_clk_i;
    logic        pulse_i;
    logic        irq_o, trig_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    lpc_timer #(.CNT_W(W)) dut_i (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_clk_i(src_clk_i), .pulse_i(pulse_i),
        .irq_o(irq_o), .trig_o(trig_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'(a);
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_cnt(output logic [31:0] d);
        wr_reg(3, 32'h0);
        rd_reg(3, d);
    endtask

    // k = 0..3 selects a clock source, k = 4 is the pulse input
    task automatic pulse(input int k, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (k == 4) pulse_i = 1'b1; else src_clk_i[k] = 1'b1;
            repeat (3) @(negedge clk);
            if (k == 4) pulse_i = 1'b0; else src_clk_i[k] = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic setup(input logic [31:0] c, input logic [31:0] p, input logic [31:0] cmp);
        wr_reg(0, 0);
        wr_reg(1, p);
        wr_reg(2, cmp);
        wr_reg(0, c);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        src_clk_i = 0; pulse_i = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd_reg(a, v); chk("R1 reg", v, 0);
        end
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 trig", 32'(trig_o), 0);

        // R3 / R2 snapshot (ctrl: en=1 mode=2 free=4 ie=8 flag=128; pre: bypass=16, src<<5)
        setup(1 | 4, 16, 200);
        pulse(0, 7);
        rd_cnt(v); chk("R3 delayed start", v, 5);
        pulse(0, 3);
        rd_reg(3, v); chk("R2 snapshot held", v, 5);
        rd_cnt(v); chk("R2 snapshot new", v, 8);

        // R4 match-reset sweep
        for (int c = 1; c <= 4; c++) begin
            setup(1, 16, c);
            pulse(0, 2);
            for (int e = 0; e <= 2 * (c + 1); e++) begin
                rd_cnt(v); chk("R4 match reset", v, e % (c + 1));
                pulse(0, 1);
            end
        end

        // R5 free-run overflow
        setup(1 | 4, 16, 3);
        pulse(0, 2 + 260);
        rd_cnt(v); chk("R5 free run wrap", v, 260 % 256);

        // R6 flag and irq
        setup(1 | 8, 16, 2);
        pulse(0, 4);
        rd_reg(0, v); chk("R6 flag set", 32'(v[7]), 1);
        chk("R6 irq high", 32'(irq_o), 1);
        wr_reg(0, 1 | 8 | 128);
        rd_reg(0, v); chk("R6 flag w1c", 32'(v[7]), 0);
        chk("R6 irq low", 32'(irq_o), 0);
        setup(1, 16, 2);
        pulse(0, 4);
        rd_reg(0, v); chk("R6 flag no ie", 32'(v[7]), 1);
        chk("R6 irq gated", 32'(irq_o), 0);

        // R7 compare zero holds trigger
        setup(1, 16, 0);
        repeat (2) @(negedge clk);
        chk("R7 trig at start", 32'(trig_o), 1);
        pulse(0, 7);
        chk("R7 trig held", 32'(trig_o), 1);
        rd_cnt(v); chk("R7 count stays", v, 0);
        wr_reg(0, 0);
        repeat (2) @(negedge clk);
        chk("R7 trig off", 32'(trig_o), 0);

        // R9 compare write lockout
        setup(1, 16, 10);
        wr_reg(2, 4);
        rd_reg(2, v); chk("R9 write ignored", v, 10);
        pulse(0, 12);
        rd_reg(0, v); chk("R9 flag before write", 32'(v[7]), 1);
        wr_reg(2, 4);
        rd_reg(2, v); chk("R9 write with flag", v, 4);
        wr_reg(0, 0);
        wr_reg(2, 7);
        rd_reg(2, v); chk("R9 write disabled", v, 7);

        // R8 disable clears state
        setup(1 | 4, 16, 3);
        pulse(0, 8);
        rd_reg(0, v); chk("R8 flag pre", 32'(v[7]), 1);
        wr_reg(0, 0);
        rd_reg(0, v); chk("R8 ctrl cleared", v, 0);
        rd_cnt(v); chk("R8 count cleared", v, 0);
        wr_reg(0, 1 | 4);
        pulse(0, 2);
        rd_cnt(v); chk("R8 sync restarted", v, 0);
        pulse(0, 1);
        rd_cnt(v); chk("R8 first count", v, 1);

        // R10 prescaler
        for (int p = 0; p < 3; p++) begin
            setup(1 | 4, p, 200);
            pulse(0, 2 + 13);
            rd_cnt(v); chk("R10 divide", v, 13 >> (p + 1));
        end
        setup(1 | 4, 16 | 2, 200);
        pulse(0, 7);
        rd_cnt(v); chk("R10 bypass", v, 5);

        // R11 source select
        for (int s = 0; s < 4; s++) begin
            setup(1 | 4, 16 | (s << 5), 200);
            for (int k = 0; k < 5; k++) if (k != s) pulse(k, 3);
            rd_cnt(v); chk("R11 others ignored", v, 0);
            pulse(s, 5);
            rd_cnt(v); chk("R11 selected", v, 3);
        end

        // R12 pulse mode
        setup(1 | 2 | 4, 16, 200);
        pulse(0, 4);
        rd_cnt(v); chk("R12 clock ignored", v, 0);
        pulse(4, 6);
        rd_cnt(v); chk("R12 pulse counted", v, 4);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule